// File: doc/BRIEF.md
# Dual-Mode Interrupt Priority Router

The router gathers four device request lines (two peripheral interface adapters, an Ethernet controller and a serial controller) plus an internal non-maskable request. It turns them into one CPU interrupt priority level from 0 to 7 and a matching autovector number. A mode input selects between two routing tables at run time. In the high mode the Ethernet request gets no CPU level. It is passed instead to a separate expansion-slot interrupt output, where a slot interrupt controller elsewhere picks it up.

The non-maskable request comes from a pulse stretcher. A trigger input starts a hold window of a fixed number of clock cycles, and a new trigger during the window restarts it. Pending state is kept per level and changes only when a source changes, with the routing table in force at that moment. A source that drops after a mode switch therefore clears the bit of its new level, not the bit of the level it originally set.

Top module: `irq_prio_router`

## Requirements
- R1: Request bit positions are fixed: `req_i[0]` is adapter 1, `req_i[1]` is adapter 2, `req_i[2]` is Ethernet and `req_i[3]` is serial. The non-maskable request is internal and is driven by `nmi_trig_i`.
- R2: With the effective mode low, adapter 1 maps to level 6, adapter 2 to level 2, Ethernet to level 3, serial to level 4 and the non-maskable request to level 7. `slot_irq_o` stays 0.
- R3: With the effective mode high, adapter 1 maps to level 1, adapter 2 to level 2, serial to level 4 and the non-maskable request to level 7. Ethernet sets no level. Each Ethernet change is copied to `slot_irq_o`, one cycle later.
- R4: A rising source sets the pending bit of its mapped level, and a falling source clears that bit. A source held steady has no effect.
- R5: `ipl_o` is the highest pending level, or 0 when nothing is pending. It is registered and reflects a request change one clock edge after that change is sampled.
- R6: `vec_o` equals `ipl_o` + 24 when `ipl_o` is nonzero, and 0 otherwise.
- R7: A cycle with `nmi_trig_i` high starts a hold of NMI_HOLD cycles during which the non-maskable request is active. `ipl_o` reads 7 from the second edge after the trigger. A trigger during the hold restarts the full count.
- R8: Synchronous reset clears all pending levels, the slot output and the outputs, forces the effective mode low and cancels any running non-maskable hold.
- R9: The effective mode is `mode_i` registered, so it takes effect one edge later. A change is written using the table in force when it is sampled. A level set in one mode therefore stays set if its source drops after a switch.
- R10: When two sources share a level, the latest change wins. When both change in the same cycle, the higher bit index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | Routing table select (0 = low table, 1 = high table) |
| req_i | input | 4 | Level-sensitive device requests: adapter 1, adapter 2, Ethernet, serial |
| nmi_trig_i | input | 1 | Starts or restarts the non-maskable hold |
| ipl_o | output | LW (3) | Highest pending interrupt level |
| vec_o | output | VEC_W (8) | Autovector number, level + 24, or 0 |
| slot_irq_o | output | 1 | Expansion-slot interrupt carrying Ethernet in high mode |

## Verification
A request change driven between edges shows on `ipl_o`, `vec_o` and `slot_irq_o` after the very next rising edge. A mode change needs one extra edge before requests are routed by the new table. A trigger needs two edges before level 7 appears. The level is released NMI_HOLD + 2 edges after the trigger, or NMI_HOLD + 2 edges after the last retrigger. The bench drives every input on the falling edge and counts falling edges to exactly those points before it compares. It also checks the edge just before a release, so an off-by-one in the hold count is caught.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  // number of request sources seen by the pending logic (4 pins + NMI)
  localparam int NSRC     = 5;
  localparam int NREQ     = NSRC - 1;
  localparam int SRC_ADP1 = 0;
  localparam int SRC_ADP2 = 1;
  localparam int SRC_ETH  = 2;
  localparam int SRC_SER  = 3;
  localparam int SRC_NMI  = 4;
endpackage

// File: rtl/irq_nmi_stretch.sv
module irq_nmi_stretch #(
  parameter int HOLD = 5_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic act
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (trig)         cnt_q <= CW'(HOLD);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign act = (cnt_q != '0);
endmodule

// File: rtl/irq_pend_update.sv
module irq_pend_update #(
  parameter int NLVL = 8,
  parameter int LW   = $clog2(NLVL),
  parameter logic [irq_router_pkg::NSRC*LW-1:0] LVL_LO = '0,
  parameter logic [irq_router_pkg::NSRC*LW-1:0] LVL_HI = '0
) (
  input  logic                            mode,
  input  logic [irq_router_pkg::NSRC-1:0] src_now,
  input  logic [irq_router_pkg::NSRC-1:0] src_prev,
  input  logic [NLVL-1:0]                 pend_cur,
  input  logic                            slot_cur,
  output logic [NLVL-1:0]                 pend_nxt,
  output logic                            slot_nxt
);
  import irq_router_pkg::*;

  logic [LW-1:0] lvl;

  // walk sources in index order: a later index overwrites an earlier one
  always_comb begin
    pend_nxt = pend_cur;
    slot_nxt = slot_cur;
    lvl      = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (src_now[i] != src_prev[i]) begin
        if (mode && (i == SRC_ETH)) begin
          slot_nxt = src_now[i];
        end else begin
          lvl = mode ? LVL_HI[i*LW +: LW] : LVL_LO[i*LW +: LW];
          if (lvl != '0) pend_nxt[lvl] = src_now[i];
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NLVL = 8,
  parameter int LW   = $clog2(NLVL)
) (
  input  logic [NLVL-1:0] pend,
  output logic [LW-1:0]   lvl
);
  // level 0 means "nothing"; bit 0 is never a request
  always_comb begin
    lvl = '0;
    for (int i = 1; i < NLVL; i++) begin
      if (pend[i]) lvl = LW'(i);
    end
  end
endmodule

// File: rtl/irq_prio_router.sv
module irq_prio_router #(
  parameter int NLVL     = 8,
  parameter int LW       = $clog2(NLVL),
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 24,
  parameter int NMI_HOLD = 5_000_000,
  // per-source level, source 0 in the low bits; level 0 = no level
  parameter logic [irq_router_pkg::NSRC*LW-1:0] LVL_LO = {3'd7, 3'd4, 3'd3, 3'd2, 3'd6},
  parameter logic [irq_router_pkg::NSRC*LW-1:0] LVL_HI = {3'd7, 3'd4, 3'd0, 3'd2, 3'd1}
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            mode_i,
  input  logic [irq_router_pkg::NREQ-1:0] req_i,
  input  logic                            nmi_trig_i,
  output logic [LW-1:0]                   ipl_o,
  output logic [VEC_W-1:0]                vec_o,
  output logic                            slot_irq_o
);
  import irq_router_pkg::*;

  logic              mode_q;
  logic              nmi_act;
  logic [NSRC-1:0]   src_now, src_q;
  logic [NLVL-1:0]   pend_q, pend_nxt;
  logic              slot_q, slot_nxt;
  logic [LW-1:0]     enc_lvl;
  logic [LW-1:0]     ipl_q;
  logic [VEC_W-1:0]  vec_q;

  irq_nmi_stretch #(.HOLD(NMI_HOLD)) u_stretch (
    .clk  (clk),
    .rst  (rst),
    .trig (nmi_trig_i),
    .act  (nmi_act)
  );

  assign src_now = {nmi_act, req_i};

  irq_pend_update #(
    .NLVL(NLVL), .LW(LW), .LVL_LO(LVL_LO), .LVL_HI(LVL_HI)
  ) u_update (
    .mode     (mode_q),
    .src_now  (src_now),
    .src_prev (src_q),
    .pend_cur (pend_q),
    .slot_cur (slot_q),
    .pend_nxt (pend_nxt),
    .slot_nxt (slot_nxt)
  );

  irq_prio_enc #(.NLVL(NLVL), .LW(LW)) u_enc (
    .pend (pend_nxt),
    .lvl  (enc_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      src_q  <= '0;
      pend_q <= '0;
      slot_q <= 1'b0;
      ipl_q  <= '0;
      vec_q  <= '0;
    end else begin
      mode_q <= mode_i;
      src_q  <= src_now;
      pend_q <= pend_nxt;
      slot_q <= slot_nxt;
      ipl_q  <= enc_lvl;
      vec_q  <= (enc_lvl == '0) ? '0 : VEC_W'(VEC_BASE) + VEC_W'(enc_lvl);
    end
  end

  assign ipl_o      = ipl_q;
  assign vec_o      = vec_q;
  assign slot_irq_o = slot_q;
endmodule

// File: rtl/irq_prio_router_chk.sv
module irq_prio_router_chk #(
  parameter int LW       = 3,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_q,
  input logic             nmi_trig,
  input logic             nmi_act,
  input logic [LW-1:0]    ipl,
  input logic [VEC_W-1:0] vec,
  input logic             slot
);
  AST_VEC_OFFSET: assert property (@(posedge clk) disable iff (rst)
    (ipl == '0) ? (vec == '0) : (vec == VEC_W'(VEC_BASE) + VEC_W'(ipl))); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (ipl == '0 && vec == '0 && !slot)); // R8

  AST_TRIG_ARMS: assert property (@(posedge clk) disable iff (rst)
    nmi_trig |=> nmi_act); // R7

  AST_NMI_ON_TOP: assert property (@(posedge clk) disable iff (rst)
    nmi_act |=> (ipl == '1)); // R7

  AST_SLOT_NEEDS_HI: assert property (@(posedge clk) disable iff (rst)
    $rose(slot) |-> $past(mode_q)); // R3
endmodule

bind irq_prio_router irq_prio_router_chk #(
  .LW(LW), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .mode_q   (mode_q),
  .nmi_trig (nmi_trig_i),
  .nmi_act  (nmi_act),
  .ipl      (ipl_o),
  .vec      (vec_o),
  .slot     (slot_irq_o)
);

// File: tb/sim_irq_prio_router.sv
module sim_irq_prio_router;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode0 = 1'b0, mode1 = 1'b0;
  logic [3:0] req0 = '0, req1 = '0;
  logic       trig0 = 1'b0, trig1 = 1'b0;
  logic [2:0] ipl0, ipl1;
  logic [7:0] vec0, vec1;
  logic       slot0, slot1;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_router #(.NMI_HOLD(HOLD)) u0 (
    .clk(clk), .rst(rst), .mode_i(mode0), .req_i(req0), .nmi_trig_i(trig0),
    .ipl_o(ipl0), .vec_o(vec0), .slot_irq_o(slot0)
  );

  // serial shares level 2 with adapter 2 in the low table
  irq_prio_router #(
    .NMI_HOLD(HOLD),
    .LVL_LO({3'd7, 3'd2, 3'd3, 3'd2, 3'd6})
  ) u1 (
    .clk(clk), .rst(rst), .mode_i(mode1), .req_i(req1), .nmi_trig_i(trig1),
    .ipl_o(ipl1), .vec_o(vec1), .slot_irq_o(slot1)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk0(input string tag, input int exp_ipl, input bit exp_slot);
    int exp_vec;
    exp_vec = (exp_ipl == 0) ? 0 : exp_ipl + 24;
    n_chk++;
    if (ipl0 !== 3'(exp_ipl) || vec0 !== 8'(exp_vec) || slot0 !== exp_slot) begin
      n_bad++;
      $display("FAIL %s: ipl=%0d vec=%0d slot=%0b expected ipl=%0d vec=%0d slot=%0b",
               tag, ipl0, vec0, slot0, exp_ipl, exp_vec, exp_slot);
    end
  endtask

  task automatic chk1(input string tag, input int exp_ipl);
    n_chk++;
    if (ipl1 !== 3'(exp_ipl)) begin
      n_bad++;
      $display("FAIL %s: ipl=%0d expected ipl=%0d", tag, ipl1, exp_ipl);
    end
  endtask

  task automatic t_reset;
    chk0("R8 reset state", 0, 0);
    chk1("R8 reset state u1", 0);
  endtask

  task automatic t_low_single;
    req0 = 4'b0001; tick(1); chk0("R2 R1 adapter1 low", 6, 0);
    req0 = 4'b0000; tick(1); chk0("R4 adapter1 release", 0, 0);
    req0 = 4'b0010; tick(1); chk0("R2 adapter2 low", 2, 0);
    req0 = 4'b0000; tick(1);
    req0 = 4'b0100; tick(1); chk0("R2 ethernet low", 3, 0);
    req0 = 4'b0000; tick(1);
    req0 = 4'b1000; tick(1); chk0("R2 R6 serial low", 4, 0);
    req0 = 4'b0000; tick(1); chk0("R5 none pending", 0, 0);
  endtask

  task automatic t_priority;
    req0 = 4'b1010; tick(1); chk0("R5 serial over adapter2", 4, 0);
    req0 = 4'b1011; tick(1); chk0("R5 adapter1 over serial", 6, 0);
    tick(2);             chk0("R4 steady no change", 6, 0);
    req0 = 4'b1010; tick(1); chk0("R5 drop adapter1", 4, 0);
    req0 = 4'b0010; tick(1); chk0("R5 drop serial", 2, 0);
    req0 = 4'b0000; tick(1); chk0("R5 all clear", 0, 0);
  endtask

  task automatic t_high_mode;
    mode0 = 1'b1; tick(1);
    chk0("R9 mode switch alone", 0, 0);
    req0 = 4'b0001; tick(1); chk0("R3 adapter1 high", 1, 0);
    req0 = 4'b0101; tick(1); chk0("R3 ethernet to slot", 1, 1);
    req0 = 4'b0001; tick(1); chk0("R3 ethernet slot drop", 1, 0);
    req0 = 4'b1001; tick(1); chk0("R3 serial high", 4, 0);
    req0 = 4'b0000; tick(1); chk0("R3 high clear", 0, 0);
    mode0 = 1'b0; tick(1);
  endtask

  task automatic t_stale;
    req0 = 4'b0001; tick(1); chk0("R9 set in low", 6, 0);
    mode0 = 1'b1; tick(1);
    req0 = 4'b0000; tick(1); chk0("R9 drop after switch keeps bit", 6, 0);
    mode0 = 1'b0; tick(1);
    req0 = 4'b0001; tick(1);
    req0 = 4'b0000; tick(1); chk0("R9 cleared back in low", 0, 0);
  endtask

  task automatic t_nmi;
    trig0 = 1'b1; tick(1); trig0 = 1'b0;
    chk0("R7 one edge after trigger", 0, 0);
    tick(1);  chk0("R7 nmi level", 7, 0);
    tick(7);  chk0("R7 last hold cycle", 7, 0);
    tick(1);  chk0("R7 released", 0, 0);
  endtask

  task automatic t_retrigger;
    trig0 = 1'b1; tick(1); trig0 = 1'b0;
    tick(4);
    trig0 = 1'b1; tick(1); trig0 = 1'b0;
    tick(4);  chk0("R7 retrigger past first release", 7, 0);
    tick(4);  chk0("R7 retrigger last cycle", 7, 0);
    tick(1);  chk0("R7 retrigger released", 0, 0);
  endtask

  task automatic t_reset_cancel;
    mode0 = 1'b1;
    trig0 = 1'b1; tick(1); trig0 = 1'b0;
    tick(2);  chk0("R7 hold before reset", 7, 0);
    rst = 1'b1; tick(1);
    chk0("R8 reset clears level", 0, 0);
    mode0 = 1'b0; rst = 1'b0;
    tick(HOLD + 2); chk0("R8 hold cancelled", 0, 0);
  endtask

  task automatic t_shared;
    req1 = 4'b0010; tick(1); chk1("R10 adapter2 sets shared", 2);
    req1 = 4'b1010; tick(1); chk1("R10 serial also sets", 2);
    req1 = 4'b1000; tick(1); chk1("R10 latest clear wins", 0);
    req1 = 4'b0010; tick(1); chk1("R10 same cycle higher index clears", 0);
    req1 = 4'b1000; tick(1); chk1("R10 same cycle higher index sets", 2);
    req1 = 4'b0000; tick(1); chk1("R10 shared cleared", 0);
  endtask

  initial begin
    tick(3);
    t_reset();
    rst = 1'b0; tick(1);
    t_reset();
    t_low_single();
    t_priority();
    t_high_mode();
    t_stale();
    t_nmi();
    t_retrigger();
    t_reset_cancel();
    t_shared();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule